// File: doc/BRIEF.md
# RFID Tag Page Pointer and ID Lock Gate

This block keeps the two address pointers a passive RFID tag uses to reach its memory: a block pointer and a page pointer. A command decoder upstream announces each command frame with a start pulse, an opcode and the page and block fields it carried. It then delivers the frame's serial data bits one at a time and marks the end of the frame with a done pulse. From this the block presents the page the array should use, and raises a single-cycle write strobe when a write command completes against a writable page.

The tag has one special identity page. While the block pointer selects it, the page pointer plays no part in the address. Writes to that page from the radio side are gated by a lock flag. The flag is taken from a fixed bit position inside write frames: the 121st bit of a page write or the 25th bit of a third-word write. A frame that ends before that position leaves the flag untouched.

Top module: `tag_page_ptr`

## Requirements
- R1: While reset is low and on release, page_addr is 0, id_space is 0, lock_bit is 0 and wr_en is 0.
- R2: A frame start with cmd_op 1 (read page) or 2 (write page) loads page_field into the page pointer. When the identity page is not selected, page_addr reads {block pointer, page pointer} from the next cycle.
- R3: A frame start with cmd_op 4 selects the identity page: id_space becomes 1 and page_addr becomes 1. cmd_op 5 loads blk_field into the block pointer and clears id_space.
- R4: In a cmd_op 2 frame, the data bit received as the 121st valid bit after frame_start becomes lock_bit on the next cycle.
- R5: In a cmd_op 3 (write third word) frame, the 25th valid bit becomes lock_bit on the next cycle.
- R6: lock_bit keeps its value when a frame ends before the sampling position, and in frames with any other opcode.
- R7: wr_en pulses for exactly one cycle, in the cycle after cmd_done, and only for frames opened with cmd_op 2 or 3.
- R8: While the identity page is selected, a write completes (wr_en) only if lock_bit, including a value sampled in that same frame, is 1.
- R9: While the identity page is not selected, a write completes only if the page pointer is below NUM_PAGES (12).
- R10: While the identity page is selected, page_addr stays 1 whatever page_field write or read commands carry. The page pointer still loads and reappears once a block is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | First cycle of a command frame; clears the bit count |
| cmd_op | input | 3 | Decoded opcode, valid with frame_start |
| page_field | input | PAGE_W | Page number carried by the command |
| blk_field | input | BLK_W | Block number carried by the command |
| bit_valid | input | 1 | A serial data bit is present |
| bit_data | input | 1 | Serial data bit |
| cmd_done | input | 1 | Last cycle of the command frame |
| page_addr | output | BLK_W+PAGE_W | Effective page address for the array |
| id_space | output | 1 | Identity page selected |
| wr_en | output | 1 | One-cycle write strobe to the array |
| lock_bit | output | 1 | Current identity-page write permission |

## Verification
A stale or corrupted page pointer shows on page_addr the cycle after the command that should have loaded it, unless the identity page is selected. It then stays hidden until the next block selection, so the sequences deliberately return to a block after identity-page work. A bit counter that is off by one moves lock sampling to a neighbouring bit. This shows on lock_bit only when adjacent bits differ, so the stimulus places a lone opposite value at the sampling position. A wrong lock or legality decision appears as a missing or extra wr_en pulse one cycle after cmd_done.

// File: rtl/tag_page_ptr.sv
module tag_page_ptr #(
  parameter int BLK_W         = 3,
  parameter int PAGE_W        = 4,
  parameter int NUM_PAGES     = 12,
  parameter int CNT_W         = 8,
  parameter int LOCK_POS_PAGE = 121,
  parameter int LOCK_POS_WORD = 25,
  parameter int ID_PAGE       = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic [2:0]              cmd_op,
  input  logic [PAGE_W-1:0]       page_field,
  input  logic [BLK_W-1:0]        blk_field,
  input  logic                    bit_valid,
  input  logic                    bit_data,
  input  logic                    cmd_done,
  output logic [BLK_W+PAGE_W-1:0] page_addr,
  output logic                    id_space,
  output logic                    wr_en,
  output logic                    lock_bit
);
  localparam int AW = BLK_W + PAGE_W;
  localparam logic [2:0] OP_RD = 3'd1;
  localparam logic [2:0] OP_WP = 3'd2;
  localparam logic [2:0] OP_W3 = 3'd3;
  localparam logic [2:0] OP_ID = 3'd4;
  localparam logic [2:0] OP_BL = 3'd5;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TAP_PG  = CNT_W'(LOCK_POS_PAGE - 1);
  localparam logic [CNT_W-1:0] TAP_W3  = CNT_W'(LOCK_POS_WORD - 1);
  localparam logic [PAGE_W:0]  PG_LIM  = (PAGE_W+1)'(NUM_PAGES);
  localparam logic [AW-1:0]    ID_ADDR = AW'(ID_PAGE);

  logic [BLK_W-1:0]  blk_q;
  logic [PAGE_W-1:0] pg_q;
  logic              id_q, lock_q, wr_q;
  logic [2:0]        kind_q;
  logic [CNT_W-1:0]  cnt_q;

  wire is_write = (kind_q == OP_WP) || (kind_q == OP_W3);
  wire tap_hit  = bit_valid && !frame_start &&
                  (((kind_q == OP_WP) && (cnt_q == TAP_PG)) ||
                   ((kind_q == OP_W3) && (cnt_q == TAP_W3)));
  wire lock_nx  = tap_hit ? bit_data : lock_q;
  wire legal    = id_q || ({1'b0, pg_q} < PG_LIM);
  wire wr_nx    = cmd_done && is_write && legal && (!id_q || lock_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      pg_q   <= '0;
      id_q   <= 1'b0;
      lock_q <= 1'b0;
      wr_q   <= 1'b0;
      kind_q <= '0;
      cnt_q  <= '0;
    end else begin
      lock_q <= lock_nx;
      wr_q   <= wr_nx;
      if (frame_start) begin
        kind_q <= cmd_op;
        cnt_q  <= '0;
        if (cmd_op == OP_RD || cmd_op == OP_WP) pg_q <= page_field;
        if (cmd_op == OP_ID) id_q <= 1'b1;
        if (cmd_op == OP_BL) begin
          blk_q <= blk_field;
          id_q  <= 1'b0;
        end
      end else begin
        if (bit_valid && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (cmd_done) kind_q <= '0;
      end
    end
  end

  assign page_addr = id_q ? ID_ADDR : {blk_q, pg_q};
  assign id_space  = id_q;
  assign wr_en     = wr_q;
  assign lock_bit  = lock_q;

  // R7
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R7
  wr_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(cmd_done));
  // R8
  id_lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && id_space) |-> lock_bit);
  // R9
  page_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !id_space) |-> ({1'b0, page_addr[PAGE_W-1:0]} < PG_LIM));
  // R6
  lock_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_bit) |-> ($past(bit_valid) && !$past(frame_start)));
  // R2
  pl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (cmd_op == OP_RD || cmd_op == OP_WP)) |=> (pg_q == $past(page_field)));
  // R3
  id_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cmd_op == OP_ID) |=> (id_space && page_addr == ID_ADDR));
endmodule

// File: tb/tag_page_ptr_tb_top.sv
module tag_page_ptr_tb_top;
  localparam int BLK_W = 3;
  localparam int PAGE_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [PAGE_W-1:0] page_field = '0;
  logic [BLK_W-1:0] blk_field = '0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic cmd_done = 1'b0;
  logic [BLK_W+PAGE_W-1:0] page_addr;
  logic id_space, wr_en, lock_bit;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;

  int m_blk, m_pg, m_id, m_lock, m_kind, m_cnt, m_wr, m_ln;

  tag_page_ptr dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cmd_op(cmd_op),
    .page_field(page_field), .blk_field(blk_field), .bit_valid(bit_valid),
    .bit_data(bit_data), .cmd_done(cmd_done), .page_addr(page_addr),
    .id_space(id_space), .wr_en(wr_en), .lock_bit(lock_bit));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // behavioural reference
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_blk = 0; m_pg = 0; m_id = 0; m_lock = 0; m_kind = 0; m_cnt = 0; m_wr = 0;
    end else begin
      m_ln = m_lock;
      if (bit_valid && !frame_start &&
          ((m_kind == 2 && m_cnt == 120) || (m_kind == 3 && m_cnt == 24)))
        m_ln = bit_data;
      m_wr = (cmd_done && (m_kind == 2 || m_kind == 3) &&
              (m_id != 0 ? m_ln == 1 : m_pg < 12)) ? 1 : 0;
      m_lock = m_ln;
      if (frame_start) begin
        m_kind = cmd_op;
        m_cnt = 0;
        if (cmd_op == 1 || cmd_op == 2) m_pg = page_field;
        if (cmd_op == 4) m_id = 1;
        if (cmd_op == 5) begin m_blk = blk_field; m_id = 0; end
      end else begin
        if (bit_valid && m_cnt < 255) m_cnt++;
        if (cmd_done) m_kind = 0;
      end
    end
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog R7 actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      int ea;
      ea = (m_id != 0) ? 1 : m_blk * 16 + m_pg;
      chk(page_addr == ea, "R2 R3 R10 page_addr", page_addr, ea);
      chk(id_space == m_id, "R3 id_space", id_space, m_id);
      chk(wr_en == m_wr, "R7 R8 R9 wr_en", wr_en, m_wr);
      chk(lock_bit == m_lock, "R4 R5 R6 lock_bit", lock_bit, m_lock);
    end
  end

  task automatic start(input int op, input int pg, input int bk);
    @(negedge clk);
    frame_start = 1'b1; cmd_op = 3'(op); page_field = PAGE_W'(pg); blk_field = BLK_W'(bk);
    @(negedge clk);
    frame_start = 1'b0; cmd_op = '0;
  endtask

  task automatic send_bits(input int n, input int tp, input bit tv, input bit fill, input bit rnd);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_data = (i == tp) ? tv : (rnd ? 1'($urandom) : fill);
    end
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic done();
    @(negedge clk);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(page_addr == 0 && id_space == 0 && lock_bit == 0 && wr_en == 0,
        "R1 reset outputs", {page_addr, id_space, lock_bit, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(page_addr == 0 && id_space == 0 && lock_bit == 0 && wr_en == 0,
        "R1 after release", {page_addr, id_space, lock_bit, wr_en}, 0);
    cmp_en = 1'b1;

    start(1, 3, 0);
    chk(page_addr == 3, "R2 read page loads", page_addr, 3);
    send_bits(16, 0, 1'b0, 1'b1, 1'b0);
    done();
    chk(wr_en == 0, "R7 read gives no write", wr_en, 0);

    start(5, 0, 2);
    chk(page_addr == 35, "R3 block select", page_addr, 35);
    done();

    start(2, 7, 0);
    send_bits(130, 121, 1'b0, 1'b1, 1'b0);
    chk(lock_bit == 0, "R4 bit 121 sampled as 0", lock_bit, 0);
    done();
    chk(wr_en == 1, "R9 legal page write", wr_en, 1);
    @(negedge clk);
    chk(wr_en == 0, "R7 single-cycle strobe", wr_en, 0);

    start(2, 13, 0);
    send_bits(130, 121, 1'b1, 1'b0, 1'b0);
    chk(lock_bit == 1, "R4 bit 121 sampled as 1", lock_bit, 1);
    done();
    chk(wr_en == 0, "R9 page 13 out of range", wr_en, 0);

    start(4, 0, 0);
    chk(id_space == 1 && page_addr == 1, "R3 identity select", page_addr, 1);

    start(2, 9, 0);
    chk(page_addr == 1, "R10 page field ignored", page_addr, 1);
    send_bits(130, 121, 1'b1, 1'b0, 1'b0);
    done();
    chk(wr_en == 1, "R8 unlocked identity write", wr_en, 1);

    start(3, 0, 0);
    send_bits(30, 25, 1'b0, 1'b1, 1'b0);
    chk(lock_bit == 0, "R5 bit 25 sampled as 0", lock_bit, 0);
    done();
    chk(wr_en == 0, "R8 locked identity write", wr_en, 0);

    start(3, 0, 0);
    send_bits(20, 0, 1'b0, 1'b1, 1'b0);
    done();
    chk(lock_bit == 0, "R6 short frame keeps lock", lock_bit, 0);
    chk(wr_en == 0, "R8 still locked", wr_en, 0);

    start(1, 2, 0);
    send_bits(130, 0, 1'b0, 1'b1, 1'b0);
    done();
    chk(lock_bit == 0, "R6 read frame keeps lock", lock_bit, 0);

    start(3, 0, 0);
    send_bits(25, 25, 1'b1, 1'b0, 1'b0);
    done();
    chk(wr_en == 1 && lock_bit == 1, "R5 R8 lock set in same frame", {wr_en, lock_bit}, 3);

    start(5, 0, 1);
    chk(page_addr == 18 && id_space == 0, "R10 R3 pointer reappears", page_addr, 18);
    start(3, 0, 0);
    send_bits(30, 25, 1'b0, 1'b1, 1'b0);
    done();
    chk(wr_en == 1, "R9 word write legal page", wr_en, 1);

    for (int f = 0; f < 300; f++) begin
      int op, n, tp;
      op = $urandom_range(0, 5);
      n = $urandom_range(0, 140);
      tp = (f % 2 == 0) ? 121 : 25;
      start(op, $urandom_range(0, 15), $urandom_range(0, 7));
      send_bits(n, tp, 1'($urandom), 1'b0, 1'b1);
      done();
    end
    @(negedge clk);
    summary();
  end
endmodule